// File: doc/BRIEF.md
# Page-Cache Line Tag Checker

This block snoops a split-transaction, pipelined memory bus. Each bus address carries a frame mode in its top two bits, so handling is known as soon as the address shows up. Frames used as a local page cache for shared pages keep a two-bit state per cache line in a small tag array. Frames backed by a remote controller carry no tags. Plain local frames are passed straight through.

For every bus transaction the block answers, one cycle later, with one of three outcomes: let the local protocol proceed, retry, or intervene and issue a remote line request. A line that is waiting for remote data is held in a transit state, and every access to it is retried until a fill completion arrives and sets the granted state. A page-init command writes one value into every tag of a frame. A frame mapped at its home node starts Exclusive. A frame mapped at a client node starts Invalid.

Remote requests leave through a one-entry valid/ready stream. While an unaccepted request is held (`rreq_valid` high, `rreq_ready` low), the block cannot take a new one, so any access that would need one is retried instead and changes no state. Fill completions are always accepted, so that port has no ready.

Top module: `ftag_checker`

## Requirements
- R1: `bus_addr[15:14]` selects the mode: 00 local, 01 page cache, 10 remote-backed, 11 handled as local. The tag index is `bus_addr[9:4]` (frame in [9:8], line in [7:4]). The line address is `bus_addr[15:4]`. Every accepted bus cycle yields `resp_valid` on the following cycle, with at most one of `resp_retry` and `resp_intervene` set.
- R2: For local-mode and mode-11 addresses, the response has neither retry nor intervene, and no remote request is raised.
- R3: Any access to a page-cache line whose tag is Transit (11) is retried, and the tag is unchanged.
- R4: Reads and writes to a page-cache line whose tag is Exclusive (10) proceed with no retry or intervene.
- R5: A read of a Shared (01) line proceeds. A write to it is answered with intervene and an exclusive request (`rreq_excl`=1), and the tag becomes Transit.
- R6: Any access to an Invalid (00) line is answered with intervene and a request whose kind equals the write flag, and the tag becomes Transit.
- R7: Every access to a remote-backed address is answered with intervene and a request whose kind equals the write flag. No tag is read or written.
- R8: If a remote request is needed while the request slot is held (`rreq_valid` high and `rreq_ready` low), the access is retried and no tag changes.
- R9: A raised request stays valid, with stable `rreq_line` and `rreq_excl`, until `rreq_ready` is seen high.
- R10: A fill whose line address (mode 01, same tag index) names a line in Transit sets that tag to Exclusive when `fill_excl`=1, otherwise to Shared.
- R11: A fill that names no page-cache line in Transit changes no tag and sets `err_sticky`, which stays set until reset.
- R12: `init_valid` writes Exclusive (`init_home`=1) or Invalid (`init_home`=0) into every tag of `init_frame`. It takes priority over a fill or bus update to that frame in the same cycle.
- R13: After reset all tags are Invalid and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus address phase present |
| bus_write | input | 1 | Transaction is a write / ownership request |
| bus_addr | input | 16 | Physical address |
| resp_valid | output | 1 | Snoop response for previous cycle's transaction |
| resp_retry | output | 1 | Retry the transaction |
| resp_intervene | output | 1 | Inhibit local memory, controller will supply |
| rreq_valid | output | 1 | Remote line request present |
| rreq_ready | input | 1 | Remote request accepted |
| rreq_line | output | 12 | Line address of the request |
| rreq_excl | output | 1 | 1 exclusive copy wanted, 0 shared |
| fill_valid | input | 1 | Remote fill completion |
| fill_line | input | 12 | Line address of the completion |
| fill_excl | input | 1 | Granted state: 1 Exclusive, 0 Shared |
| init_valid | input | 1 | Page-init command |
| init_frame | input | 2 | Frame to initialise |
| init_home | input | 1 | 1 home mapping (Exclusive), 0 client (Invalid) |
| err_sticky | output | 1 | A fill matched no transit line |

## Verification
Every result is registered once. The response to a bus address sampled at a rising edge, the request it raises, and any tag, fill or init effect are all visible after that same edge. A tag effect therefore shapes the response to the next transaction on that line. The bench drives inputs on the falling edge and, before each edge, computes from its own tag model what the outputs will show. It then compares at the next falling edge, one full cycle after the stimulus.

// File: rtl/ftag_pkg.sv
package ftag_pkg;
  typedef enum logic [1:0] {
    TAG_INV = 2'b00,
    TAG_SHR = 2'b01,
    TAG_EXC = 2'b10,
    TAG_TRN = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    MODE_LOCAL  = 2'b00,
    MODE_CACHE  = 2'b01,
    MODE_REMOTE = 2'b10,
    MODE_SPARE  = 2'b11
  } mode_e;

  typedef struct packed {
    logic retry;
    logic intervene;
    logic need_req;
    logic req_excl;
    logic tag_we;
    tag_e tag_new;
  } verdict_t;
endpackage

// File: rtl/ftag_decode.sv
module ftag_decode
  import ftag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int IDX_W   = 6,
  localparam int LA_W   = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output mode_e             mode,
  output logic [IDX_W-1:0]  idx,
  output logic [LA_W-1:0]   line_addr
);
  logic unused_bits;
  assign unused_bits = ^addr;
  assign mode      = mode_e'(addr[ADDR_W-1 -: 2]);
  assign idx       = addr[OFF_W+IDX_W-1:OFF_W];
  assign line_addr = addr[ADDR_W-1:OFF_W];
endmodule

// File: rtl/ftag_store.sv
module ftag_store
  import ftag_pkg::*;
#(
  parameter int FRAME_W = 2,
  parameter int LIDX_W  = 4,
  localparam int IDX_W   = FRAME_W + LIDX_W,
  localparam int LINES   = 1 << LIDX_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_a_idx,
  output tag_e               rd_a_tag,
  input  logic [IDX_W-1:0]   rd_b_idx,
  output tag_e               rd_b_tag,
  input  logic               init_we,
  input  logic [FRAME_W-1:0] init_frame,
  input  tag_e               init_tag,
  input  logic               fill_we,
  input  logic [IDX_W-1:0]   fill_idx,
  input  tag_e               fill_tag,
  input  logic               bus_we,
  input  logic [IDX_W-1:0]   bus_idx,
  input  tag_e               bus_tag
);
  logic [2*ENTRIES-1:0] tags_flat;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [FRAME_W-1:0] MY_FRAME = FRAME_W'(e / LINES);
    localparam logic [IDX_W-1:0]   MY_IDX   = IDX_W'(e);
    tag_e q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= TAG_INV;
      else if (init_we && init_frame == MY_FRAME) q <= init_tag;
      else if (fill_we && fill_idx == MY_IDX)     q <= fill_tag;
      else if (bus_we && bus_idx == MY_IDX)       q <= bus_tag;
    end
    assign tags_flat[2*e +: 2] = q;
  end

  assign rd_a_tag = tag_e'(tags_flat[{rd_a_idx, 1'b0} +: 2]);
  assign rd_b_tag = tag_e'(tags_flat[{rd_b_idx, 1'b0} +: 2]);
endmodule

// File: rtl/ftag_policy.sv
module ftag_policy
  import ftag_pkg::*;
(
  input  logic     valid,
  input  logic     write,
  input  mode_e    mode,
  input  tag_e     tag,
  input  logic     slot_free,
  output verdict_t v
);
  always_comb begin
    v = '{retry: 1'b0, intervene: 1'b0, need_req: 1'b0, req_excl: 1'b0,
          tag_we: 1'b0, tag_new: TAG_INV};
    if (valid) begin
      unique case (mode)
        MODE_REMOTE: begin
          if (slot_free) begin
            v.intervene = 1'b1;
            v.need_req  = 1'b1;
            v.req_excl  = write;
          end else begin
            v.retry = 1'b1;
          end
        end
        MODE_CACHE: begin
          unique case (tag)
            TAG_TRN: v.retry = 1'b1;
            TAG_EXC: ;
            TAG_SHR: begin
              if (write) begin
                if (slot_free) begin
                  v.intervene = 1'b1;
                  v.need_req  = 1'b1;
                  v.req_excl  = 1'b1;
                  v.tag_we    = 1'b1;
                  v.tag_new   = TAG_TRN;
                end else begin
                  v.retry = 1'b1;
                end
              end
            end
            TAG_INV: begin
              if (slot_free) begin
                v.intervene = 1'b1;
                v.need_req  = 1'b1;
                v.req_excl  = write;
                v.tag_we    = 1'b1;
                v.tag_new   = TAG_TRN;
              end else begin
                v.retry = 1'b1;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ftag_rreq.sv
module ftag_rreq #(
  parameter int LA_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LA_W-1:0] load_line,
  input  logic            load_excl,
  output logic            slot_free,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [LA_W-1:0] out_line,
  output logic            out_excl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_line  <= '0;
      out_excl  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_line  <= load_line;
      out_excl  <= load_excl;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
  assign slot_free = !out_valid || out_ready;
endmodule

// File: rtl/ftag_checker.sv
module ftag_checker
  import ftag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 2,
  parameter int LIDX_W  = 4,
  localparam int IDX_W  = FRAME_W + LIDX_W,
  localparam int LA_W   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               resp_valid,
  output logic               resp_retry,
  output logic               resp_intervene,
  output logic               rreq_valid,
  input  logic               rreq_ready,
  output logic [LA_W-1:0]    rreq_line,
  output logic               rreq_excl,
  input  logic               fill_valid,
  input  logic [LA_W-1:0]    fill_line,
  input  logic               fill_excl,
  input  logic               init_valid,
  input  logic [FRAME_W-1:0] init_frame,
  input  logic               init_home,
  output logic               err_sticky
);
  mode_e            bus_mode, fill_mode;
  logic [IDX_W-1:0] bus_idx, fill_idx;
  logic [LA_W-1:0]  bus_line, fill_unused_line;
  tag_e             bus_tag, fill_tag_cur;
  verdict_t         verdict;
  logic             slot_free, fill_ok;

  ftag_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dec_bus (
    .addr(bus_addr), .mode(bus_mode), .idx(bus_idx), .line_addr(bus_line));

  ftag_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dec_fill (
    .addr({fill_line, {OFF_W{1'b0}}}), .mode(fill_mode), .idx(fill_idx),
    .line_addr(fill_unused_line));

  ftag_policy u_policy (
    .valid(bus_valid), .write(bus_write), .mode(bus_mode), .tag(bus_tag),
    .slot_free(slot_free), .v(verdict));

  assign fill_ok = fill_valid && fill_mode == MODE_CACHE && fill_tag_cur == TAG_TRN;

  ftag_store #(.FRAME_W(FRAME_W), .LIDX_W(LIDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(bus_idx), .rd_a_tag(bus_tag),
    .rd_b_idx(fill_idx), .rd_b_tag(fill_tag_cur),
    .init_we(init_valid), .init_frame(init_frame),
    .init_tag(init_home ? TAG_EXC : TAG_INV),
    .fill_we(fill_ok), .fill_idx(fill_idx),
    .fill_tag(fill_excl ? TAG_EXC : TAG_SHR),
    .bus_we(verdict.tag_we), .bus_idx(bus_idx), .bus_tag(verdict.tag_new));

  ftag_rreq #(.LA_W(LA_W)) u_rreq (
    .clk(clk), .rst_n(rst_n),
    .load(verdict.need_req), .load_line(bus_line), .load_excl(verdict.req_excl),
    .slot_free(slot_free),
    .out_valid(rreq_valid), .out_ready(rreq_ready),
    .out_line(rreq_line), .out_excl(rreq_excl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_retry     <= 1'b0;
      resp_intervene <= 1'b0;
      err_sticky     <= 1'b0;
    end else begin
      resp_valid     <= bus_valid;
      resp_retry     <= verdict.retry;
      resp_intervene <= verdict.intervene;
      err_sticky     <= err_sticky | (fill_valid && !fill_ok);
    end
  end
endmodule

// File: rtl/ftag_checker_sva.sv
module ftag_checker_sva #(
  parameter int ADDR_W = 16,
  parameter int LA_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              resp_valid,
  input logic              resp_retry,
  input logic              resp_intervene,
  input logic              rreq_valid,
  input logic              rreq_ready,
  input logic [LA_W-1:0]   rreq_line,
  input logic              rreq_excl,
  input logic              err_sticky
);
  // R1
  resp_follows_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> resp_valid);
  // R1
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_retry && resp_intervene));
  // R2
  local_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_addr[ADDR_W-1 -: 2] == 2'b00 || bus_addr[ADDR_W-1 -: 2] == 2'b11))
    |=> (!resp_retry && !resp_intervene));
  // R7
  remote_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[ADDR_W-1 -: 2] == 2'b10) |=> (resp_retry || resp_intervene));
  // R9
  rreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rreq_valid && !rreq_ready) |=> (rreq_valid && $stable(rreq_line) && $stable(rreq_excl)));
  // R6
  rreq_needs_intervene_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rreq_valid) |-> resp_intervene);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

bind ftag_checker ftag_checker_sva #(.ADDR_W(ADDR_W), .LA_W(LA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .resp_valid(resp_valid), .resp_retry(resp_retry), .resp_intervene(resp_intervene),
  .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rreq_line(rreq_line),
  .rreq_excl(rreq_excl), .err_sticky(err_sticky));

// File: tb/ftag_checker_tb_top.sv
module ftag_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = '0;
  logic        resp_valid, resp_retry, resp_intervene;
  logic        rreq_valid, rreq_excl;
  logic        rreq_ready = 0;
  logic [11:0] rreq_line;
  logic        fill_valid = 0, fill_excl = 0;
  logic [11:0] fill_line = '0;
  logic        init_valid = 0, init_home = 0;
  logic [1:0]  init_frame = '0;
  logic        err_sticky;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model: tag per index (00 I, 01 S, 10 E, 11 T)
  logic [1:0]  m_tag [64];
  logic        m_pv = 0, m_pex = 0, m_err = 0;
  logic [11:0] m_pline = '0;

  always #5 clk = ~clk;

  ftag_checker dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .resp_valid(resp_valid), .resp_retry(resp_retry),
    .resp_intervene(resp_intervene), .rreq_valid(rreq_valid), .rreq_ready(rreq_ready),
    .rreq_line(rreq_line), .rreq_excl(rreq_excl), .fill_valid(fill_valid),
    .fill_line(fill_line), .fill_excl(fill_excl), .init_valid(init_valid),
    .init_frame(init_frame), .init_home(init_home), .err_sticky(err_sticky));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic decide(input logic [1:0] mode, input logic [1:0] tag, input logic wr,
                        input logic free, output logic rt, output logic iv,
                        output logic rq, output logic ex, output logic twe,
                        output string rule);
    rt = 0; iv = 0; rq = 0; ex = 0; twe = 0; rule = "R2";
    if (mode == 2'b10) begin
      rule = free ? "R7" : "R8";
      if (free) begin iv = 1; rq = 1; ex = wr; end else rt = 1;
    end else if (mode == 2'b01) begin
      case (tag)
        2'b11: begin rule = "R3"; rt = 1; end
        2'b10: rule = "R4";
        2'b01: begin
          rule = "R5";
          if (wr) begin
            if (free) begin iv = 1; rq = 1; ex = 1; twe = 1; end
            else begin rt = 1; rule = "R8"; end
          end
        end
        default: begin
          rule = "R6";
          if (free) begin iv = 1; rq = 1; ex = wr; twe = 1; end
          else begin rt = 1; rule = "R8"; end
        end
      endcase
    end
  endtask

  // Inputs are already driven; predict, clock one edge, compare at the next falling edge.
  task automatic step();
    logic rt, iv, rq, ex, twe, free, fok;
    logic [5:0] bidx, fidx;
    string rule;
    bidx = bus_addr[9:4];
    fidx = fill_line[5:0];
    free = !m_pv || rreq_ready;
    decide(bus_addr[15:14], m_tag[bidx], bus_write, free, rt, iv, rq, ex, twe, rule);
    if (!bus_valid) begin rt = 0; iv = 0; rq = 0; twe = 0; end
    fok = fill_valid && fill_line[11:10] == 2'b01 && m_tag[fidx] == 2'b11;
    @(posedge clk);
    @(negedge clk);
    // apply in priority order: bus, fill (R10), init (R12) last
    if (twe) m_tag[bidx] = 2'b11;
    if (fok) m_tag[fidx] = fill_excl ? 2'b10 : 2'b01;
    if (fill_valid && !fok) m_err = 1;
    if (init_valid)
      for (int l = 0; l < 16; l++) m_tag[{init_frame, 4'(l)}] = init_home ? 2'b10 : 2'b00;
    if (rq) begin m_pv = 1; m_pline = bus_addr[15:4]; m_pex = ex; end
    else if (rreq_ready) m_pv = 0;
    chk("R1", "resp_valid", resp_valid, bus_valid);
    chk(rule, "resp_retry", resp_retry, rt);
    chk(rule, "resp_intervene", resp_intervene, iv);
    chk("R9", "rreq_valid", rreq_valid, m_pv);
    if (m_pv) begin
      chk("R9", "rreq_line", rreq_line, m_pline);
      chk("R9", "rreq_excl", rreq_excl, m_pex);
    end
    chk("R11", "err_sticky", err_sticky, m_err);
  endtask

  task automatic idle();
    bus_valid = 0; fill_valid = 0; init_valid = 0;
  endtask

  task automatic bus(input logic [1:0] mode, input logic [1:0] fr, input logic [3:0] ln,
                     input logic wr);
    idle();
    bus_valid = 1; bus_write = wr; bus_addr = {mode, 4'h0, fr, ln, 4'h5};
    step();
  endtask

  task automatic fill(input logic [1:0] mode, input logic [1:0] fr, input logic [3:0] ln,
                      input logic ex);
    idle();
    fill_valid = 1; fill_line = {mode, 4'h0, fr, ln}; fill_excl = ex;
    step();
  endtask

  task automatic init(input logic [1:0] fr, input logic home);
    idle();
    init_valid = 1; init_frame = fr; init_home = home;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_7a61));
    for (int i = 0; i < 64; i++) m_tag[i] = 2'b00;
    repeat (3) @(negedge clk);
    // R13: reset state of outputs
    chk("R13", "resp_valid", resp_valid, 0);
    chk("R13", "rreq_valid", rreq_valid, 0);
    chk("R13", "err_sticky", err_sticky, 0);
    rst_n = 1;
    @(negedge clk);
    rreq_ready = 1;
    // R13/R6: after reset a page-cache line is Invalid
    bus(2'b01, 2'd3, 4'd9, 0);
    // R12: home init -> Exclusive; R4 read and write pass
    init(2'd0, 1);
    bus(2'b01, 2'd0, 4'd1, 0);
    bus(2'b01, 2'd0, 4'd15, 1);
    // R12 client init -> Invalid; R6 read miss raises shared request
    init(2'd1, 0);
    bus(2'b01, 2'd1, 4'd2, 0);
    // R3: transit line retried
    bus(2'b01, 2'd1, 4'd2, 1);
    // R8/R9: hold the slot, then a miss is retried
    rreq_ready = 0;
    bus(2'b01, 2'd1, 4'd3, 1);
    bus(2'b01, 2'd1, 4'd4, 1);
    bus(2'b10, 2'd1, 4'd4, 0);
    rreq_ready = 1;
    idle(); step();
    // R11: fill of a non-transit line, and of a non-cache mode
    fill(2'b01, 2'd1, 4'd5, 1);
    fill(2'b00, 2'd1, 4'd2, 1);
    // R10: fill granting Shared, then reads pass, write upgrades (R5)
    fill(2'b01, 2'd1, 4'd2, 0);
    bus(2'b01, 2'd1, 4'd2, 0);
    bus(2'b01, 2'd1, 4'd2, 1);
    fill(2'b01, 2'd1, 4'd2, 1);
    bus(2'b01, 2'd1, 4'd2, 1);
    // R2: local and spare modes pass through
    bus(2'b00, 2'd1, 4'd7, 1);
    bus(2'b11, 2'd1, 4'd7, 0);
    // R7: remote-backed accesses
    bus(2'b10, 2'd2, 4'd0, 1);
    bus(2'b10, 2'd2, 4'd0, 0);
    // R12: init beats a same-cycle fill to a transit line in that frame
    bus(2'b01, 2'd2, 4'd6, 0);
    idle();
    init_valid = 1; init_frame = 2'd2; init_home = 0;
    fill_valid = 1; fill_line = {2'b01, 4'h0, 2'd2, 4'd6}; fill_excl = 1;
    step();
    bus(2'b01, 2'd2, 4'd6, 0);
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] mr;
      logic [1:0] md;
      idle();
      rreq_ready = ($urandom % 3) != 0;
      bus_valid  = ($urandom % 4) != 0;
      bus_write  = $urandom % 2;
      mr = 3'($urandom % 8);
      md = (mr < 2) ? 2'b00 : (mr < 6) ? 2'b01 : (mr == 6) ? 2'b10 : 2'b11;
      bus_addr = {md, 4'($urandom), 2'($urandom), 2'b00, 2'($urandom), 4'($urandom)};
      fill_valid = ($urandom % 4) == 0;
      fill_line  = {(($urandom % 8) == 0) ? 2'b10 : 2'b01, 4'($urandom), 2'($urandom),
                    2'b00, 2'($urandom)};
      fill_excl  = $urandom % 2;
      init_valid = ($urandom % 40) == 0;
      init_frame = 2'($urandom);
      init_home  = $urandom % 2;
      step();
    end
    idle(); step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule